// File: doc/BRIEF.md
# Competition Countdown Timer with Menu/Game PRG Select

This block is an add-on for a cartridge mapper that is already serially loaded. It uses the mapper's 5-bit "select" register (the first character-bank register) for two jobs. First, it runs a long countdown of CPU cycles and raises an interrupt request when the countdown expires. A 4-bit DIP switch sets the length of the countdown by forcing high bits of the compare value. Second, it chooses the outer program-ROM region. One region is a 32K menu area in the lower 128K, switched in 32K steps. The other is a game area in the upper 128K, where the mapper's usual 16K banking modes apply.

The surrounding mapper presents three things. One is the serial-write result for the select register, with a one-cycle strobe. Another is the control-register mode and program-bank values, which it has already latched. The last is a CPU cycle enable. The block returns a level interrupt request and the physical program-ROM address. Character memory is one fixed 8K RAM, so the character address passes through unchanged.

The select register bits are used as follows:
- Bit 4 holds and clears the timer.
- Bit 3 picks game (1) or menu (0).
- Bits 2:1 choose the 32K menu bank.
- Bit 0 is unused.

Top module: `comp_timer_sel`

## Requirements
- R1: After synchronous reset, irq is low, the counter is zero and the latched select register is zero, which means menu bank 0 and timer running.
- R2: The counter advances by one on each clock where cpu_ce is high and bit 4 of the latched select register is clear. It does not advance on any other clock.
- R3: A sel_wr with sel_data bit 4 set clears the counter and drops irq at that clock edge. This clear wins over an expiry in the same cycle, and the counter then stays at zero for as long as the latched bit 4 stays set.
- R4: On a counting clock, the incremented count is ORed with the sampled DIP value shifted left by DIP_LSB. When that result has every bit from DIP_LSB upward set, irq is raised and the counter returns to 0. With the defaults (30-bit counter, DIP_LSB 25) this is the compare result being at least 0x3E000000.
- R5: irq is a level. It stays high through further counting and through select writes with bit 4 clear, until a clearing write (R3).
- R6: dip_sw passes through one register, which resets to 0xE, before it reaches the compare. A new DIP setting therefore changes the expiry length without producing an irq pulse.
- R7: In menu mode (latched bit 3 clear), prg_addr = {1'b0, sel[2:1], cpu_addr[14:0]}.
- R8: In game mode (bit 3 set), prg_addr = {1'b1, b[2:0], cpu_addr[13:0]}. Here b is the 16K bank for the half chosen by cpu_addr[14], and it depends on ctrl_mode[3:2]:
  - For 11, the low half is prg_bank[2:0] and the high half is 7.
  - For 10, the low half is 0 and the high half is prg_bank[2:0].
  - For 0x, the low half is {prg_bank[2:1],0} and the high half is {prg_bank[2:1],1}.
- R9: chr_addr always equals ppu_addr, whatever the register values.
- R10: The select register changes only on a sel_wr strobe. Without the strobe, changes on sel_data have no effect on prg_addr or the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | One-clock CPU cycle enable |
| sel_wr | input | 1 | Strobe: select register written this clock |
| sel_data | input | 5 | Value written to the select register |
| ctrl_mode | input | 5 | Latched mapper control register (bits 3:2 PRG mode) |
| prg_bank | input | 5 | Latched mapper PRG bank register |
| dip_sw | input | DIP_W | Countdown length switches |
| cpu_addr | input | 15 | CPU address within the 32K ROM window |
| ppu_addr | input | 13 | PPU address within pattern space |
| irq | output | 1 | Level interrupt request |
| prg_addr | output | 18 | Physical PRG-ROM byte address |
| chr_addr | output | 13 | Address into the 8K CHR RAM |

## Verification
Two events can fall in the same clock: the counting step that would expire the timer, and a clearing write to the select register. The bench runs the counter to exactly one step before expiry. It then applies the final cpu_ce together with a sel_wr carrying bit 4 on the same edge. The test passes only if irq stays low. After the timer is released, the bench also requires a full countdown before the next irq, which shows the counter was zeroed rather than wrapped.

// File: rtl/comp_timer_pkg.sv
package comp_timer_pkg;

    localparam int SEL_W     = 5;
    localparam int PRG_AW    = 18;
    localparam int WIN_AW    = 15;
    localparam int BANK16_AW = 14;
    localparam int CHR_AW    = 13;

    // Select register layout; field order matters (bit 4 down to bit 0)
    typedef struct packed {
        logic       hold;       // bit 4: stop and clear timer
        logic       game_en;    // bit 3: game region vs menu
        logic [1:0] menu_bank;  // bits 2:1: 32K menu bank
        logic       spare;      // bit 0
    } sel_reg_t;

    // Control register bits 3:2 PRG organisation
    typedef enum logic [1:0] {
        PM_WIDE_A = 2'b00,
        PM_WIDE_B = 2'b01,
        PM_FIX_LO = 2'b10,
        PM_FIX_HI = 2'b11
    } prg_mode_e;

    // Inner 16K bank (3 bits) for the half selected by upper_half
    function automatic logic [2:0] inner_bank(prg_mode_e mode,
                                              logic [3:0] bank,
                                              logic upper_half);
        logic [2:0] b;
        unique case (mode)
            PM_FIX_HI: b = upper_half ? 3'd7 : bank[2:0];
            PM_FIX_LO: b = upper_half ? bank[2:0] : 3'd0;
            default:   b = {bank[2:1], upper_half};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/comp_timer_count.sv
module comp_timer_count #(
    parameter int          DIP_W       = 4,
    parameter int          DIP_LSB     = 25,
    parameter logic [3:0]  DIP_DEFAULT = 4'hE,
    localparam int         CNT_W       = DIP_LSB + DIP_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             clear,
    input  logic [DIP_W-1:0] dip_sw,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] LOW_MASK = (CNT_W'(1) << DIP_LSB) - CNT_W'(1);
    localparam logic [CNT_W-1:0] THRESH   = ~LOW_MASK;

    logic [DIP_W-1:0] dip_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cmp_val;
    logic             irq_q;
    logic             expire;

    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        cmp_val = cnt_inc | (CNT_W'(dip_q) << DIP_LSB);
        expire  = (cmp_val >= THRESH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dip_q <= DIP_W'(DIP_DEFAULT);
        end else begin
            dip_q <= dip_sw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (step_en) begin
            if (expire) begin
                cnt_q <= '0;
                irq_q <= 1'b1;
            end else begin
                cnt_q <= cnt_inc;
            end
        end
    end

    assign count = cnt_q;
    assign irq   = irq_q;
endmodule

// File: rtl/comp_timer_prgmap.sv
module comp_timer_prgmap
    import comp_timer_pkg::*;
(
    input  sel_reg_t          sel,
    input  logic [SEL_W-1:0]  ctrl_mode,
    input  logic [SEL_W-1:0]  prg_bank,
    input  logic [WIN_AW-1:0] cpu_addr,
    output logic [PRG_AW-1:0] prg_addr
);
    prg_mode_e  mode;
    logic [2:0] game_bank;

    always_comb begin
        mode      = prg_mode_e'(ctrl_mode[3:2]);
        game_bank = inner_bank(mode, prg_bank[3:0], cpu_addr[WIN_AW-1]);
        if (sel.game_en) begin
            prg_addr = {1'b1, game_bank, cpu_addr[BANK16_AW-1:0]};
        end else begin
            prg_addr = {1'b0, sel.menu_bank, cpu_addr};
        end
    end
endmodule

// File: rtl/comp_timer_sel.sv
module comp_timer_sel
    import comp_timer_pkg::*;
#(
    parameter int         DIP_W       = 4,
    parameter int         DIP_LSB     = 25,
    parameter logic [3:0] DIP_DEFAULT = 4'hE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ce,
    input  logic              sel_wr,
    input  logic [4:0]        sel_data,
    input  logic [4:0]        ctrl_mode,
    input  logic [4:0]        prg_bank,
    input  logic [DIP_W-1:0]  dip_sw,
    input  logic [14:0]       cpu_addr,
    input  logic [12:0]       ppu_addr,
    output logic              irq,
    output logic [17:0]       prg_addr,
    output logic [12:0]       chr_addr
);
    localparam int CNT_W = DIP_LSB + DIP_W + 1;

    sel_reg_t         sel_q;
    sel_reg_t         sel_new;
    logic             tmr_clear;
    logic             tmr_step;
    logic [CNT_W-1:0] tmr_cnt;

    assign sel_new   = sel_reg_t'(sel_data);
    assign tmr_clear = sel_wr & sel_new.hold;
    assign tmr_step  = cpu_ce & ~sel_q.hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= sel_new;
        end
    end

    comp_timer_count #(
        .DIP_W      (DIP_W),
        .DIP_LSB    (DIP_LSB),
        .DIP_DEFAULT(DIP_DEFAULT)
    ) u_count (
        .clk    (clk),
        .rst    (rst),
        .step_en(tmr_step),
        .clear  (tmr_clear),
        .dip_sw (dip_sw),
        .count  (tmr_cnt),
        .irq    (irq)
    );

    comp_timer_prgmap u_prgmap (
        .sel      (sel_q),
        .ctrl_mode(ctrl_mode),
        .prg_bank (prg_bank),
        .cpu_addr (cpu_addr),
        .prg_addr (prg_addr)
    );

    assign chr_addr = ppu_addr;
endmodule

// File: rtl/comp_timer_sel_chk.sv
module comp_timer_sel_chk #(
    parameter int CNT_W = 30
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_ce,
    input logic             sel_wr,
    input logic [4:0]       sel_data,
    input logic             hold_bit,
    input logic             game_bit,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [17:0]      prg_addr,
    input logic [12:0]      chr_addr,
    input logic [12:0]      ppu_addr
);
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && sel_data[4]) |=> (!irq && cnt == '0)); // R3

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (hold_bit && !sel_wr) |=> $stable(cnt)); // R2

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ce && !sel_wr) |=> $stable(cnt)); // R2

    AST_EXPIRE_RESTART: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (cnt == '0)); // R4

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq && !(sel_wr && sel_data[4])) |=> irq); // R5

    AST_REGION_SPLIT: assert property (@(posedge clk) disable iff (rst)
        prg_addr[17] == game_bit); // R7

    AST_CHR_FIXED: assert property (@(posedge clk) disable iff (rst)
        chr_addr == ppu_addr); // R9
endmodule

bind comp_timer_sel comp_timer_sel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cpu_ce  (cpu_ce),
    .sel_wr  (sel_wr),
    .sel_data(sel_data),
    .hold_bit(sel_q.hold),
    .game_bit(sel_q.game_en),
    .irq     (irq),
    .cnt     (tmr_cnt),
    .prg_addr(prg_addr),
    .chr_addr(chr_addr),
    .ppu_addr(ppu_addr)
);

// File: tb/comp_timer_sel_tb.sv
`timescale 1ns/1ps
module comp_timer_sel_tb;
    localparam int DIP_W   = 4;
    localparam int DIP_LSB = 4;
    localparam int CNT_W   = DIP_LSB + DIP_W + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_ce;
    logic        sel_wr;
    logic [4:0]  sel_data;
    logic [4:0]  ctrl_mode;
    logic [4:0]  prg_bank;
    logic [3:0]  dip_sw;
    logic [14:0] cpu_addr;
    logic [12:0] ppu_addr;
    logic        irq;
    logic [17:0] prg_addr;
    logic [12:0] chr_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    comp_timer_sel #(.DIP_W(DIP_W), .DIP_LSB(DIP_LSB), .DIP_DEFAULT(4'hE)) u_dut (
        .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .sel_wr(sel_wr),
        .sel_data(sel_data), .ctrl_mode(ctrl_mode), .prg_bank(prg_bank),
        .dip_sw(dip_sw), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .irq(irq), .prg_addr(prg_addr), .chr_addr(chr_addr)
    );

    // counting steps to first expiry: top bit plus cleared DIP positions
    function automatic int steps_for(logic [3:0] d);
        return (1 << (CNT_W - 1)) + (int'(~d & 4'hF) << DIP_LSB);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_sel(logic [4:0] v);
        @(negedge clk); sel_wr = 1'b1; sel_data = v;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic run_ce(int n);
        if (n > 0) begin
            @(negedge clk); cpu_ce = 1'b1;
            repeat (n) @(negedge clk);
            cpu_ce = 1'b0;
        end
    endtask

    task automatic arm(logic [3:0] d);
        dip_sw = d;
        wr_sel(5'h10);
        repeat (3) @(negedge clk);
        wr_sel(5'h00);
    endtask

    task automatic t_reset;
        rst = 1'b1; cpu_ce = 0; sel_wr = 0; sel_data = 0;
        ctrl_mode = 0; prg_bank = 0; dip_sw = 4'hE; cpu_addr = 15'h0123; ppu_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq", irq, 0);
        check("R1 prg", prg_addr, 18'h00123);
    endtask

    task automatic t_expiry(logic [3:0] d);
        int k = steps_for(d);
        arm(d);
        run_ce(k - 1);
        check("R4 before", irq, 0);
        run_ce(1);
        check("R4 at", irq, 1);
    endtask

    task automatic t_gating;
        int k = steps_for(4'hF);
        arm(4'hF);
        run_ce(100);
        repeat (50) @(negedge clk);
        run_ce(k - 101);
        check("R2 gap", irq, 0);
        run_ce(1);
        check("R2 gap end", irq, 1);
    endtask

    task automatic t_hold;
        int k = steps_for(4'hF);
        arm(4'hF);
        wr_sel(5'h10);
        run_ce(1000);
        check("R3 held", irq, 0);
        wr_sel(5'h00);
        run_ce(k - 1);
        check("R3 after hold", irq, 0);
        run_ce(1);
        check("R3 after hold end", irq, 1);
    endtask

    task automatic t_level;
        int k = steps_for(4'hF);
        run_ce(k + 5);
        check("R5 stays", irq, 1);
        wr_sel(5'h00);
        check("R5 plain write", irq, 1);
        wr_sel(5'h10);
        check("R3 clear", irq, 0);
    endtask

    task automatic t_collide;
        int k = steps_for(4'hF);
        arm(4'hF);
        run_ce(k - 1);
        @(negedge clk); cpu_ce = 1'b1; sel_wr = 1'b1; sel_data = 5'h10;
        @(negedge clk); cpu_ce = 1'b0; sel_wr = 1'b0;
        check("R3 collide", irq, 0);
        wr_sel(5'h00);
        run_ce(k - 1);
        check("R3 restart", irq, 0);
        run_ce(1);
        check("R3 restart end", irq, 1);
    endtask

    task automatic t_dip_change;
        int k = steps_for(4'h0);
        wr_sel(5'h10);
        dip_sw = 4'h0;
        repeat (4) @(negedge clk);
        check("R6 no pulse", irq, 0);
        wr_sel(5'h00);
        run_ce(k - 1);
        check("R6 long", irq, 0);
        run_ce(1);
        check("R6 long end", irq, 1);
    endtask

    task automatic t_prg;
        wr_sel(5'h04);
        cpu_addr = 15'h1234; #1;
        check("R7 menu2", prg_addr, 18'h11234);
        wr_sel(5'h06);
        cpu_addr = 15'h7FFF; #1;
        check("R7 menu3", prg_addr, 18'h1FFFF);
        sel_data = 5'h0A; #1;
        check("R10 no strobe", prg_addr, 18'h1FFFF);
        wr_sel(5'h08);
        ctrl_mode = 5'h0C; prg_bank = 5'h05;
        cpu_addr = 15'h0100; #1; check("R8 fixhi lo", prg_addr, 18'h34100);
        cpu_addr = 15'h4100; #1; check("R8 fixhi hi", prg_addr, 18'h3C100);
        prg_bank = 5'h0D;
        cpu_addr = 15'h0100; #1; check("R8 bank3 dropped", prg_addr, 18'h34100);
        ctrl_mode = 5'h08; prg_bank = 5'h0B;
        cpu_addr = 15'h0100; #1; check("R8 fixlo lo", prg_addr, 18'h20100);
        cpu_addr = 15'h4100; #1; check("R8 fixlo hi", prg_addr, 18'h2C100);
        ctrl_mode = 5'h00; prg_bank = 5'h06;
        cpu_addr = 15'h0100; #1; check("R8 wide lo", prg_addr, 18'h38100);
        cpu_addr = 15'h4100; #1; check("R8 wide hi", prg_addr, 18'h3C100);
        ctrl_mode = 5'h04; prg_bank = 5'h03;
        cpu_addr = 15'h0100; #1; check("R8 wideb lo", prg_addr, 18'h28100);
        cpu_addr = 15'h4100; #1; check("R8 wideb hi", prg_addr, 18'h2C100);
    endtask

    task automatic t_chr;
        ppu_addr = 13'h1ABC; #1;
        check("R9 chr", chr_addr, 13'h1ABC);
        ppu_addr = 13'h0007; #1;
        check("R9 chr2", chr_addr, 13'h0007);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_expiry(4'hE);
        t_expiry(4'hF);
        t_gating();
        t_hold();
        t_level();
        t_collide();
        t_dip_change();
        t_expiry(4'h5);
        t_prg();
        t_chr();
        finish_up();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule